// File: doc/BRIEF.md
# Prioritized Event Interrupt Controller

This block gathers eight numbered event requests into a pending mask and raises a single fast-interrupt line towards a processor while any request is outstanding. A readable index output names the event that software should service next. Lower event numbers win when the index is chosen.

Software acknowledges events by pulsing a clear strobe. Only every fourth strobe actually retires an event. On that strobe the lowest pending event is dropped and the index moves on to the lowest event still waiting. Synchronous reset leaves the timer event (number 2) already pending, so the interrupt line is asserted straight out of reset.

Top module: `evtIrqTop`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `pendMask` is 0x04 (bit 2 set), `curEvent` is 2 and `fiqOut` is 1. The clear counter starts from zero.
- R2: A cycle with `evtValid` high sets bit `evtNum` of `pendMask` at the next clock edge.
- R3: On an event, `curEvent` takes the value `evtNum` only when the index is 0 or `evtNum` is less than the index. Otherwise it keeps its value. The index used for this comparison is the one that results after any retire in the same cycle.
- R4: Clear strobes are counted modulo 4 from reset. The first, second and third strobe of each group of four leave `pendMask` and `curEvent` unchanged.
- R5: The fourth clear strobe of each group clears the lowest set bit of `pendMask`.
- R6: After that bit is cleared, `curEvent` is loaded with the number of the lowest bit still set. If no bit remains set, `curEvent` keeps its value.
- R7: `fiqOut` is 1 exactly when `pendMask` is non-zero, and both change at the same clock edge.
- R8: When an event and a fourth clear strobe arrive in the same cycle, the retire is applied first and the event is merged afterwards. An event equal to the retired number therefore stays pending.
- R9: Clear strobes that arrive while `pendMask` is zero advance the counter and change nothing else.
- R10: A cycle with neither strobe leaves `pendMask`, `curEvent` and `fiqOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evtValid | input | 1 | One-cycle event request strobe |
| evtNum | input | 3 | Number of the requesting event |
| clrStrobe | input | 1 | Acknowledge strobe from a register write |
| fiqOut | output | 1 | Fast-interrupt request to the processor |
| curEvent | output | 3 | Index of the event to service |
| pendMask | output | 8 | Pending events, one bit per event number |

## Verification
The assertions assume that `evtNum` is a valid number whenever `evtValid` is high. They also assume that each clear strobe is a single cycle that the block counts exactly once. The bench drives both strobes as single-cycle pulses at the falling clock edge, with event numbers drawn only from 0 to 7. The bench sweeps every ordered pair of events and every same-cycle collision of an event with a retire. It also drains a full mask and runs a long pseudo-random mix of strobes. All of this stays inside those assumptions, and a reference kept in the bench tracks the counter phase independently.

// File: rtl/evtIrqPkg.sv
package evtIrqPkg;
  // Strobes passed from the acknowledge control to the datapath
  typedef struct packed {
    logic retire;  // this clear strobe retires the lowest pending event
    logic merge;   // an incoming event is merged this cycle
  } ctrlStrobes_t;
endpackage

// File: rtl/evtLowFind.sv
module evtLowFind #(
  parameter int NUM_EVENTS = 8,
  localparam int IDX_W = $clog2(NUM_EVENTS)
) (
  input  logic [NUM_EVENTS-1:0] maskIn,
  output logic                  found,
  output logic [IDX_W-1:0]      lowIdx,
  output logic [NUM_EVENTS-1:0] lowOneHot
);
  logic [NUM_EVENTS-1:0] belowEmpty;

  // belowEmpty[g] is high when no bit under position g is set
  assign belowEmpty[0] = 1'b1;
  genvar g;
  generate
    for (g = 1; g < NUM_EVENTS; g++) begin : g_chain
      assign belowEmpty[g] = belowEmpty[g-1] & ~maskIn[g-1];
    end
  endgenerate

  assign lowOneHot = maskIn & belowEmpty;
  assign found     = |maskIn;

  always_comb begin
    lowIdx = '0;
    for (int i = 0; i < NUM_EVENTS; i++) begin
      if (lowOneHot[i]) lowIdx = lowIdx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/evtClearCtrl.sv
module evtClearCtrl
  import evtIrqPkg::*;
#(
  parameter int CLEAR_DIV = 4,
  localparam int CNT_W = (CLEAR_DIV > 1) ? $clog2(CLEAR_DIV) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evtValid,
  input  logic         clrStrobe,
  output ctrlStrobes_t strobes
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CLEAR_DIV - 1);

  logic [CNT_W-1:0] clrCount;
  logic             lastOfGroup;

  assign lastOfGroup = (clrCount == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      clrCount <= '0;
    end else if (clrStrobe) begin
      clrCount <= lastOfGroup ? '0 : clrCount + 1'b1;
    end
  end

  always_comb begin
    strobes.retire = clrStrobe & lastOfGroup;
    strobes.merge  = evtValid;
  end
endmodule

// File: rtl/evtIrqDatapath.sv
module evtIrqDatapath
  import evtIrqPkg::*;
#(
  parameter int NUM_EVENTS  = 8,
  parameter int RESET_EVENT = 2,
  localparam int IDX_W = $clog2(NUM_EVENTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobes_t          strobes,
  input  logic [IDX_W-1:0]      evtNum,
  output logic                  fiqOut,
  output logic [IDX_W-1:0]      curEvent,
  output logic [NUM_EVENTS-1:0] pendMask
);
  localparam logic [NUM_EVENTS-1:0] RST_MASK = NUM_EVENTS'(1) << RESET_EVENT;
  localparam logic [IDX_W-1:0]      RST_IDX  = IDX_W'(RESET_EVENT);

  logic [NUM_EVENTS-1:0] oldLowHot, restLowHot, restMask, mergedMask, evtHot;
  logic [IDX_W-1:0]      oldLowIdx, restLowIdx, idxAfterRetire, idxNext;
  logic                  oldFound, restFound;

  // Lowest pending event before the retire
  evtLowFind #(.NUM_EVENTS(NUM_EVENTS)) u_findOld (
    .maskIn(pendMask), .found(oldFound), .lowIdx(oldLowIdx), .lowOneHot(oldLowHot)
  );

  assign restMask = strobes.retire ? (pendMask & ~oldLowHot) : pendMask;

  // Lowest event still pending after the retire
  evtLowFind #(.NUM_EVENTS(NUM_EVENTS)) u_findRest (
    .maskIn(restMask), .found(restFound), .lowIdx(restLowIdx), .lowOneHot(restLowHot)
  );

  always_comb begin
    idxAfterRetire = (strobes.retire && restFound) ? restLowIdx : curEvent;
    evtHot         = strobes.merge ? (NUM_EVENTS'(1) << evtNum) : '0;
    mergedMask     = restMask | evtHot;
    idxNext        = idxAfterRetire;
    if (strobes.merge && ((idxAfterRetire == '0) || (evtNum < idxAfterRetire)))
      idxNext = evtNum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendMask <= RST_MASK;
      curEvent <= RST_IDX;
      fiqOut   <= 1'b1;
    end else begin
      pendMask <= mergedMask;
      curEvent <= idxNext;
      fiqOut   <= |mergedMask;
    end
  end
endmodule

// File: rtl/evtIrqTop.sv
module evtIrqTop
  import evtIrqPkg::*;
#(
  parameter int NUM_EVENTS  = 8,
  parameter int CLEAR_DIV   = 4,
  parameter int RESET_EVENT = 2,
  localparam int IDX_W = $clog2(NUM_EVENTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  evtValid,
  input  logic [IDX_W-1:0]      evtNum,
  input  logic                  clrStrobe,
  output logic                  fiqOut,
  output logic [IDX_W-1:0]      curEvent,
  output logic [NUM_EVENTS-1:0] pendMask
);
  ctrlStrobes_t strobes;

  evtClearCtrl #(.CLEAR_DIV(CLEAR_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .evtValid(evtValid), .clrStrobe(clrStrobe), .strobes(strobes)
  );

  evtIrqDatapath #(.NUM_EVENTS(NUM_EVENTS), .RESET_EVENT(RESET_EVENT)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .evtNum(evtNum),
    .fiqOut(fiqOut), .curEvent(curEvent), .pendMask(pendMask)
  );
endmodule

// File: rtl/evtIrqChecker.sv
module evtIrqChecker #(
  parameter int NUM_EVENTS  = 8,
  parameter int CLEAR_DIV   = 4,
  parameter int RESET_EVENT = 2,
  localparam int IDX_W = $clog2(NUM_EVENTS),
  localparam int CNT_W = (CLEAR_DIV > 1) ? $clog2(CLEAR_DIV) : 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  evtValid,
  input logic [IDX_W-1:0]      evtNum,
  input logic                  clrStrobe,
  input logic                  fiqOut,
  input logic [IDX_W-1:0]      curEvent,
  input logic [NUM_EVENTS-1:0] pendMask
);
  localparam logic [NUM_EVENTS-1:0] RST_MASK = NUM_EVENTS'(1) << RESET_EVENT;
  localparam logic [CNT_W-1:0]      LAST_CNT = CNT_W'(CLEAR_DIV - 1);

  // Independent tally of clear strobes within the current group
  logic [CNT_W-1:0] clrSeen;
  always_ff @(posedge clk) begin
    if (rst) clrSeen <= '0;
    else if (clrStrobe) clrSeen <= (clrSeen == LAST_CNT) ? '0 : clrSeen + 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pendMask == RST_MASK && curEvent == IDX_W'(RESET_EVENT) && fiqOut)); // R1

  AST_EVENT_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
    evtValid |=> pendMask[$past(evtNum)]); // R2

  AST_EARLY_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (clrStrobe && clrSeen != LAST_CNT && !evtValid) |=> (pendMask == $past(pendMask) && $stable(curEvent))); // R4

  AST_RETIRE_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (clrStrobe && clrSeen == LAST_CNT && !evtValid) |=> (pendMask == ($past(pendMask) & ($past(pendMask) - 1'b1)))); // R5

  AST_FIQ_TRACKS_MASK: assert property (@(posedge clk) disable iff (rst)
    fiqOut == (pendMask != '0)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!evtValid && !clrStrobe) |=> ($stable(pendMask) && $stable(curEvent) && $stable(fiqOut))); // R10
endmodule

bind evtIrqTop evtIrqChecker #(
  .NUM_EVENTS(NUM_EVENTS), .CLEAR_DIV(CLEAR_DIV), .RESET_EVENT(RESET_EVENT)
) u_evtIrqChecker (
  .clk(clk), .rst(rst), .evtValid(evtValid), .evtNum(evtNum), .clrStrobe(clrStrobe),
  .fiqOut(fiqOut), .curEvent(curEvent), .pendMask(pendMask)
);

// File: tb/test_evtIrqTop.sv
`timescale 1ns/1ps
module test_evtIrqTop;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evtValid = 1'b0;
  logic [2:0] evtNum = '0;
  logic       clrStrobe = 1'b0;
  logic       fiqOut;
  logic [2:0] curEvent;
  logic [7:0] pendMask;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Reference state kept by the bench
  logic [7:0] mdlMask;
  logic [2:0] mdlIdx;
  int         mdlCnt;

  always #4 clk = ~clk;  // 125 MHz

  evtIrqTop i_evtIrqTop (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtNum(evtNum), .clrStrobe(clrStrobe),
    .fiqOut(fiqOut), .curEvent(curEvent), .pendMask(pendMask)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    cmp(tag, "pendMask", int'(pendMask), int'(mdlMask));
    cmp(tag, "curEvent", int'(curEvent), int'(mdlIdx));
    cmp(tag, "fiqOut",   int'(fiqOut),   (mdlMask != 0) ? 1 : 0);
  endtask

  function automatic int lowestOf(input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; evtValid = 1'b0; clrStrobe = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mdlMask = 8'h04; mdlIdx = 3'd2; mdlCnt = 0;
  endtask

  // One clock with the given strobes; reference updated per the requirements
  task automatic step(input logic ev, input logic [2:0] n, input logic cl, input string tag);
    @(negedge clk);
    evtValid = ev; evtNum = n; clrStrobe = cl;
    @(posedge clk);
    #1;
    evtValid = 1'b0; clrStrobe = 1'b0;
    if (cl) begin
      mdlCnt++;
      if (mdlCnt == 4) begin
        mdlCnt = 0;
        if (mdlMask != 0) begin
          mdlMask[lowestOf(mdlMask)] = 1'b0;           // R5
          if (mdlMask != 0) mdlIdx = 3'(lowestOf(mdlMask)); // R6
        end
      end
    end
    if (ev) begin
      mdlMask[n] = 1'b1;                                // R2
      if (mdlIdx == 0 || n < mdlIdx) mdlIdx = n;        // R3
    end
    checkAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    doReset();
    checkAll("R1");
    cmp("R1", "pendMask", int'(pendMask), 8'h04);

    // Idle cycles hold everything
    for (int k = 0; k < 3; k++) step(1'b0, 3'd0, 1'b0, "R10");

    // Every ordered pair of events, then a full clear group
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        doReset();
        step(1'b1, 3'(a), 1'b0, "R2");
        step(1'b1, 3'(b), 1'b0, "R3");
        for (int c = 0; c < 3; c++) step(1'b0, 3'd0, 1'b1, "R4");
        step(1'b0, 3'd0, 1'b1, "R5");
        cmp("R6", "curEvent", int'(curEvent), int'(mdlIdx));
      end
    end

    // Fill all events, drain completely, then clear with empty mask
    doReset();
    for (int e = 7; e >= 0; e--) step(1'b1, 3'(e), 1'b0, "R3");
    for (int c = 0; c < 32; c++) step(1'b0, 3'd0, 1'b1, "R6");
    cmp("R7", "fiqOut", int'(fiqOut), 0);
    for (int c = 0; c < 7; c++) step(1'b0, 3'd0, 1'b1, "R9");
    step(1'b1, 3'd5, 1'b0, "R9");
    cmp("R9", "curEvent", int'(curEvent), 5);
    step(1'b0, 3'd0, 1'b1, "R9");  // completes the group: retires event 5
    cmp("R7", "fiqOut", int'(fiqOut), 0);

    // Event colliding with the retiring strobe
    for (int n = 0; n < 8; n++) begin
      doReset();
      step(1'b1, 3'd4, 1'b0, "R8");
      for (int c = 0; c < 3; c++) step(1'b0, 3'd0, 1'b1, "R8");
      step(1'b1, 3'(n), 1'b1, "R8");
      if (n == 2) cmp("R8", "pendMask[2]", int'(pendMask[2]), 1);
    end

    // Long pseudo-random mix
    doReset();
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[5], lfsr[3:1], lfsr[7] | lfsr[9], "R3");
    end

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule